// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block deserialises stereo two's-complement audio from a single data line. A frame clock marks which channel is on the line, and a bit clock marks when each data bit is valid. The bit clock can come from an external pin. It can also be made inside the block from the master clock, which is the block's own clock `clk`. In that case the block measures how many master-clock cycles one frame-clock period lasts, and from that measurement it derives the divide ratio. The ratio depends on both the measured period and the selected data format. All inputs are synchronous to `clk`.

A compile-time parameter selects one of three formats:
- standard two-channel inter-IC audio framing (I2S);
- left-justified;
- 16-bit right-justified.

Each completed frame produces a left/right pair on the outputs together with a one-cycle `sample_valid` strobe. The output stream has no ready input and no back-pressure. Audio arrives at a fixed rate and cannot be held off, so the consumer must take the pair in the strobe cycle. Both outputs then hold their values until the next strobe.

Top module: `arx_serial_rx`

## Requirements
- R1: A data bit is taken on each rising bit-clock event. Words arrive MSB first and are passed through bit for bit, so negative two's-complement values keep their sign.
- R2: I2S format (FMT_I2S): the left word is sent while the frame clock is low and the right word while it is high. The MSB is in the second bit slot after a frame-clock edge, and up to 24 bits are taken. The last bit may fall in slot 0 of the following half.
- R3: Left-justified format (FMT_LJ): the left word is sent while the frame clock is high. The MSB is in the first bit slot after the edge, and up to 24 bits are taken.
- R4: Right-justified format (FMT_RJ16): the left word is sent while the frame clock is high. The word is the last 16 bits before the frame-clock edge that ends the half. It is placed in output bits [23:16+...8], that is bits [23:8].
- R5: Words shorter than 24 bits are left-aligned, with the unused low bits reading zero. Bit slots beyond the 24th in a half are ignored.
- R6: With the internal clock, the measured period P selects the bits per frame:
  - I2S and RJ use 32 for P in {64,128,256,512,1024}; LJ uses 64 for these.
  - All formats use 48 for P in {96,192,384,768}.
  - All formats use 72 for P = 1152.
  - The divide ratio is N = P / bits per frame. Bit slots restart at every frame-clock edge, and the sampling point lies N/2 cycles into each slot.
- R7: With the internal clock, a measured period outside the supported set produces no `sample_valid` pulses.
- R8: With `use_ext_bclk` = 1, bits are taken on detected rising edges of `ext_bclk`, whatever the frame-clock period.
- R9: `sample_valid` is a one-cycle pulse raised after a right word completes, with both outputs updated in the same cycle. Completion happens:
  - in I2S, at the second bit slot of the next half;
  - in LJ, at the first bit slot of the next half;
  - in RJ, at the frame-clock edge.
  Outputs are stable while `sample_valid` is low.
- R10: While reset is asserted, `out_left` and `out_right` read zero and `sample_valid` reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic and inputs run on it |
| rst_n | input | 1 | Active-low synchronous reset |
| use_ext_bclk | input | 1 | 1 selects the external bit clock, 0 the internal divider |
| ext_bclk | input | 1 | External bit clock, sampled by clk |
| lrck | input | 1 | Frame clock; its level selects the channel |
| sdin | input | 1 | Serial audio data |
| out_left | output | OUT_W | Left sample, left-aligned |
| out_right | output | OUT_W | Right sample, left-aligned |
| sample_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
The bench runs all three format variants side by side on a shared frame clock. Each variant is tried at frame periods of 256, 384, 1152 and 64 master cycles. These periods give half-frames of 16, 24, 32 and 36 slots, so the bench can tell the 24-bit limit apart from 16-bit truncation, and the I2S one-slot delay apart from left-justified timing. Filler bits in the unused slots show that out-of-word data is discarded. The words include extremes such as 0x800000, 0x7FFFFF and 0x000001, so sign and LSB handling are visible. An unsupported period of 200 cycles must stay silent. An external-clock run at 80 bits per frame, a rate the internal divider cannot produce, shows that the external path is independent of the ratio table.

// File: rtl/arx_pkg.sv
package arx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ16 = 2'd2
  } fmt_e;

  localparam int DIV_W = 6;

  // Master cycles per bit slot for a measured frame period; 0 = unsupported.
  function automatic logic [DIV_W-1:0] div_for_ratio(input int period, input fmt_e f);
    logic lj;
    lj = (f == FMT_LJ);
    case (period)
      64:      div_for_ratio = lj ? 6'd1  : 6'd2;
      128:     div_for_ratio = lj ? 6'd2  : 6'd4;
      256:     div_for_ratio = lj ? 6'd4  : 6'd8;
      512:     div_for_ratio = lj ? 6'd8  : 6'd16;
      1024:    div_for_ratio = lj ? 6'd16 : 6'd32;
      96:      div_for_ratio = 6'd2;
      192:     div_for_ratio = 6'd4;
      384:     div_for_ratio = 6'd8;
      768:     div_for_ratio = 6'd16;
      1152:    div_for_ratio = 6'd16;
      default: div_for_ratio = 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/arx_ratio_detect.sv
module arx_ratio_detect
  import arx_pkg::*;
#(
  parameter fmt_e FMT   = FMT_I2S,
  parameter int   CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrck_rise,
  output logic [DIV_W-1:0] div_n
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] period_cnt;
  logic             seen_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_cnt <= '0;
      seen_rise  <= 1'b0;
      div_n      <= '0;
    end else if (lrck_rise) begin
      if (seen_rise) div_n <= div_for_ratio(32'(period_cnt), FMT);
      period_cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
      seen_rise  <= 1'b1;
    end else if (period_cnt != CNT_MAX) begin
      period_cnt <= period_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/arx_bclk_gen.sv
module arx_bclk_gen
  import arx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_ext,
  input  logic             ext_bclk,
  input  logic             lrck_edge,
  input  logic [DIV_W-1:0] div_n,
  output logic             bit_tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_eff;
  logic             sclk_q;
  logic             int_tick;
  logic             ext_tick;

  assign div_eff  = lrck_edge ? '0 : div_q;
  assign int_tick = (div_n != '0) && (div_eff == (div_n >> 1));
  assign ext_tick = ext_bclk & ~sclk_q;
  assign bit_tick = use_ext ? ext_tick : int_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= ext_bclk;
      if (div_n == '0 || div_eff >= div_n - 1'b1) div_q <= '0;
      else                                        div_q <= div_eff + 1'b1;
    end
  end

  // R6
  int_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !use_ext && div_n > 6'd1) |=> (!bit_tick || use_ext || !$stable(div_n)));

  // R8
  ext_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && use_ext) |=> (!bit_tick || !use_ext));

endmodule

// File: rtl/arx_deframer.sv
module arx_deframer
  import arx_pkg::*;
#(
  parameter fmt_e FMT   = FMT_I2S,
  parameter int   OUT_W = 24,
  parameter int   RJ_W  = 16,
  parameter int   POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrck,
  input  logic             lrck_edge,
  input  logic             bit_tick,
  input  logic             clk_ok,
  input  logic             sdin,
  output logic             commit,
  output logic             commit_right,
  output logic [OUT_W-1:0] commit_word
);

  localparam int CW = $clog2(OUT_W + 1);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_eff;
  logic             half_left;

  assign pos_eff   = lrck_edge ? '0 : pos_q;
  assign half_left = (FMT == FMT_I2S) ? ~lrck : lrck;

  always_ff @(posedge clk) begin
    if (!rst_n)                              pos_q <= '0;
    else if (bit_tick && pos_eff != POS_MAX) pos_q <= pos_eff + 1'b1;
    else if (bit_tick || lrck_edge)          pos_q <= pos_eff;
  end

  generate
    if (FMT == FMT_RJ16) begin : g_rj
      logic [RJ_W-1:0] shreg;
      logic [RJ_W-1:0] last_bits;

      assign last_bits    = bit_tick ? {shreg[RJ_W-2:0], sdin} : shreg;
      assign commit       = lrck_edge && clk_ok;
      assign commit_right = lrck;
      assign commit_word  = {last_bits, {(OUT_W-RJ_W){1'b0}}};

      always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (bit_tick) shreg <= {shreg[RJ_W-2:0], sdin};
      end
    end else begin : g_aligned
      localparam logic [POS_W-1:0] START = (FMT == FMT_I2S) ? POS_W'(1) : POS_W'(0);
      localparam logic [CW-1:0]    FULL  = CW'(OUT_W);

      logic [OUT_W-1:0] acc;
      logic [CW-1:0]    nbits;
      logic             active;
      logic             acc_right;
      logic             word_start;

      assign word_start   = bit_tick && (pos_eff == START);
      assign commit       = word_start && active;
      assign commit_right = acc_right;
      assign commit_word  = acc;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          acc       <= '0;
          nbits     <= '0;
          active    <= 1'b0;
          acc_right <= 1'b0;
        end else if (word_start) begin
          acc       <= {sdin, {(OUT_W-1){1'b0}}};
          nbits     <= CW'(1);
          active    <= 1'b1;
          acc_right <= ~half_left;
        end else if (bit_tick && active && nbits < FULL) begin
          acc   <= acc | ({sdin, {(OUT_W-1){1'b0}}} >> nbits);
          nbits <= nbits + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/arx_serial_rx.sv
module arx_serial_rx
  import arx_pkg::*;
#(
  parameter fmt_e FMT   = FMT_I2S,
  parameter int   OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_ext_bclk,
  input  logic             ext_bclk,
  input  logic             lrck,
  input  logic             sdin,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right,
  output logic             sample_valid
);

  logic             lrck_q;
  logic             lrck_edge;
  logic             lrck_rise;
  logic [DIV_W-1:0] div_n;
  logic             bit_tick;
  logic             clk_ok;
  logic             commit;
  logic             commit_right;
  logic [OUT_W-1:0] commit_word;
  logic [OUT_W-1:0] hold_left;

  assign lrck_edge = lrck ^ lrck_q;
  assign lrck_rise = lrck & ~lrck_q;
  assign clk_ok    = use_ext_bclk | (div_n != '0);

  arx_ratio_detect #(.FMT(FMT)) u_ratio (
    .clk(clk), .rst_n(rst_n), .lrck_rise(lrck_rise), .div_n(div_n)
  );

  arx_bclk_gen u_bclk (
    .clk(clk), .rst_n(rst_n), .use_ext(use_ext_bclk), .ext_bclk(ext_bclk),
    .lrck_edge(lrck_edge), .div_n(div_n), .bit_tick(bit_tick)
  );

  arx_deframer #(.FMT(FMT), .OUT_W(OUT_W)) u_deframe (
    .clk(clk), .rst_n(rst_n), .lrck(lrck), .lrck_edge(lrck_edge),
    .bit_tick(bit_tick), .clk_ok(clk_ok), .sdin(sdin),
    .commit(commit), .commit_right(commit_right), .commit_word(commit_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lrck_q       <= 1'b0;
      hold_left    <= '0;
      out_left     <= '0;
      out_right    <= '0;
      sample_valid <= 1'b0;
    end else begin
      lrck_q       <= lrck;
      sample_valid <= 1'b0;
      if (commit && !commit_right) hold_left <= commit_word;
      if (commit && commit_right) begin
        out_left     <= hold_left;
        out_right    <= commit_word;
        sample_valid <= 1'b1;
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(out_left) && $stable(out_right)));

  // R7
  no_lock_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_ext_bclk && div_n == '0) |=> !sample_valid);

endmodule

// File: tb/arx_serial_rx_bench.sv
module arx_serial_rx_bench;
  import arx_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic use_ext = 1'b0;
  logic sclk = 1'b0;
  logic lrck = 1'b0;
  logic [2:0] sd = 3'b000;
  logic [23:0] l0, r0, l1, r1, l2, r2;
  logic v0, v1, v2;

  always #2.5 clk = ~clk;

  arx_serial_rx #(.FMT(FMT_I2S)) u_arx_serial_rx (
    .clk(clk), .rst_n(rst_n), .use_ext_bclk(use_ext), .ext_bclk(sclk), .lrck(lrck),
    .sdin(sd[0]), .out_left(l0), .out_right(r0), .sample_valid(v0));
  arx_serial_rx #(.FMT(FMT_LJ)) u_arx_serial_rx_lj (
    .clk(clk), .rst_n(rst_n), .use_ext_bclk(use_ext), .ext_bclk(sclk), .lrck(lrck),
    .sdin(sd[1]), .out_left(l1), .out_right(r1), .sample_valid(v1));
  arx_serial_rx #(.FMT(FMT_RJ16)) u_arx_serial_rx_rj (
    .clk(clk), .rst_n(rst_n), .use_ext_bclk(use_ext), .ext_bclk(sclk), .lrck(lrck),
    .sdin(sd[2]), .out_left(l2), .out_right(r2), .sample_valid(v2));

  int n_checks = 0;
  int n_fail = 0;
  bit armed = 1'b0;
  logic [47:0] q0[$];
  logic [47:0] q1[$];
  logic [47:0] q2[$];
  logic        lvl = 1'b0;
  logic        p1_lvl = 1'b0, p2_lvl = 1'b0;
  logic [23:0] p1_w = '0, p2_w = '0;

  function automatic string req_of(int f);
    return (f == 0) ? "R2" : (f == 1) ? "R3" : "R4";
  endfunction

  // Slots per half frame (R6 table; R8 uses 80 bits per frame with 4-cycle slots)
  function automatic int slots(int p, int f, bit ext);
    if (ext) return p / 8;
    case (p)
      1152:             return 36;
      96, 192, 384, 768: return 24;
      default:          return (f == 1) ? 32 : 16;
    endcase
  endfunction

  // R5: left-aligned, zero-filled
  function automatic logic [23:0] expv(int f, int s, logic [23:0] w);
    int wd;
    if (f == 2) return {w[23:8], 8'h00};
    wd = (s < 24) ? s : 24;
    return w & (24'hFFFFFF << (24 - wd));
  endfunction

  function automatic logic bitv(int f, int s, int j, logic [23:0] w, logic [23:0] pw);
    int k;
    logic filler;
    filler = ~j[0];
    if (f == 0) begin
      if (j == 0) begin k = s - 1; return (k < 24) ? pw[23-k] : filler; end
      k = j - 1; return (k < 24) ? w[23-k] : filler;
    end else if (f == 1) begin
      k = j; return (k < 24) ? w[23-k] : filler;
    end
    k = j - (s - 16);
    return (k >= 0 && k < 16) ? w[23-k] : filler;
  endfunction

  task automatic drive_half(input int p, input logic [23:0] w, input bit ext, input bit supp);
    if (armed && supp) begin
      for (int f = 0; f < 3; f++) begin
        logic lft;
        logic [47:0] e;
        lft = (f == 0) ? 1'b0 : 1'b1;
        if (p1_lvl != lft && p2_lvl == lft) begin
          e = {expv(f, slots(p, f, ext), p2_w), expv(f, slots(p, f, ext), p1_w)};
          case (f)
            0: q0.push_back(e);
            1: q1.push_back(e);
            default: q2.push_back(e);
          endcase
        end
      end
    end
    for (int h = 0; h < p / 2; h++) begin
      @(posedge clk); #1;
      lrck = lvl;
      sclk = ext && ((h % 4) >= 2);
      for (int f = 0; f < 3; f++) begin
        int s, n;
        s = slots(p, f, ext);
        n = (p / 2) / s;
        sd[f] = bitv(f, s, h / n, w, p1_w);
      end
    end
    p2_lvl = p1_lvl; p2_w = p1_w;
    p1_lvl = lvl;    p1_w = w;
    lvl = ~lvl;
  endtask

  task automatic check_drained(input string tag);
    n_checks++;
    if (q0.size() != 0 || q1.size() != 0 || q2.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing pulses: left %0d/%0d/%0d expected 0/0/0", tag,
               q0.size(), q1.size(), q2.size());
    end
  endtask

  task automatic run_phase(input int p, input bit ext, input bit supp, input int nh, input string tag);
    armed = 1'b0;
    use_ext = ext;
    for (int i = 0; i < 8; i++) drive_half(p, $urandom & 24'hFFFFFF, ext, supp);
    armed = 1'b1;
    drive_half(p, 24'h800000, ext, supp);   // R1 most negative
    drive_half(p, 24'h7FFFFF, ext, supp);   // R1 most positive
    drive_half(p, 24'h000001, ext, supp);   // R5 LSB only
    drive_half(p, 24'hA5C3F1, ext, supp);
    for (int i = 0; i < nh; i++) drive_half(p, $urandom & 24'hFFFFFF, ext, supp);
    check_drained(tag);
    armed = 1'b0;
  endtask

  task automatic chk(input int f, input logic v, input logic [23:0] l, input logic [23:0] r);
    logic [47:0] e;
    int sz;
    if (!v || !armed) return;
    n_checks++;
    sz = (f == 0) ? q0.size() : (f == 1) ? q1.size() : q2.size();
    if (sz == 0) begin
      n_fail++;
      $display("FAIL R9/R7 %s unexpected pulse: got %h/%h expected none", req_of(f), l, r);
      return;
    end
    case (f)
      0: e = q0.pop_front();
      1: e = q1.pop_front();
      default: e = q2.pop_front();
    endcase
    if ({l, r} !== e) begin
      n_fail++;
      $display("FAIL %s R1/R5/R6 pair: got %h/%h expected %h/%h", req_of(f), l, r, e[47:24], e[23:0]);
    end
  endtask

  always @(negedge clk) begin
    chk(0, v0, l0, r0);
    chk(1, v1, l1, r1);
    chk(2, v2, l2, r2);
  end

  task automatic chk_reset(input string when);
    n_checks++;
    if ({v0, v1, v2} !== 3'b000 || {l0, r0, l1, r1, l2, r2} !== '0) begin
      n_fail++;
      $display("FAIL R10 %s: valid %b outputs %h %h %h expected 000 and zero", when,
               {v0, v1, v2}, l0, l1, l2);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk_reset("during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset("after release");
    run_phase(256,  1'b0, 1'b1, 12, "R6 ratio 256");
    run_phase(384,  1'b0, 1'b1, 12, "R6 ratio 384");
    run_phase(1152, 1'b0, 1'b1, 8,  "R6 ratio 1152");
    run_phase(64,   1'b0, 1'b1, 12, "R6 ratio 64");
    run_phase(200,  1'b0, 1'b0, 8,  "R7 unsupported ratio");
    run_phase(320,  1'b1, 1'b1, 12, "R8 external clock");
    run_phase(256,  1'b0, 1'b1, 6,  "R6 relock 256");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule